// File: doc/BRIEF.md
# Two-Requester Banked Load Store

This block is a single-level data store split into independent word-wide banks and shared by two load requesters, standing in for two hardware threads on one core. Each line is 64 bytes. The byte offset inside the line picks one of eight 8-byte banks, and the bits above the line offset pick the line. In any cycle each requester may present one load. Two loads that land in different banks are both served in that cycle. Two loads that land in the same bank collide, even when their lines differ. One of them is served and the other is held back.

When loads collide, a single priority bit decides which one is served. The bit flips after every collision, so the requester that lost goes first at the next collision. A load that is held raises its requester's stall output. The requester must keep the request unchanged until the stall drops. A served load returns its word one cycle later. Each requester has a stall-cycle counter that it can clear. A thread can use this counter to measure the extra latency a burst of loads suffered from bank contention. A simple write port loads words into the banks. The line count is a parameter: 512 lines gives the 32 KiB configuration of 64 sets by 8 ways.

Top module: `bank_conflict_store`

## Requirements
- R1: After reset, no response is valid, neither stall is high, both stall counters read zero, and the first collision is won by requester 0.
- R2: The bank is byte-address bits [5:3]. Loads from both requesters to different banks are both served in the same cycle, with no stall, and both responses are valid on the next cycle.
- R3: Two valid loads with equal bits [5:3] collide, whether their lines differ or their addresses are identical. Exactly one of the two stalls in that cycle.
- R4: Each collision hands priority to the requester that lost it. Back-to-back bursts to one bank therefore alternate winners.
- R5: A requester never stalls in two consecutive cycles, so a held load is served in the cycle after its stall.
- R6: The response word is the word last written at line index address[ADDR_W-1:6], bank address[5:3]. It is valid exactly one cycle after the load was served. Address bits [2:0] have no effect.
- R7: A requester's counter rises by one for each cycle its stall is high. Its clear input forces the counter to zero on the next edge, and the clear wins over a stall in the same cycle.
- R8: A fill write and a load to the same word in the same cycle return the old word to the load. A later load sees the new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req0Valid | input | 1 | Requester 0 presents a load |
| req0Addr | input | ADDR_W | Requester 0 byte address |
| req0Stall | output | 1 | Requester 0 load held by a bank collision |
| rsp0Valid | output | 1 | Requester 0 load word valid |
| rsp0Data | output | 64 | Requester 0 load word |
| cntClr0 | input | 1 | Clear requester 0 stall counter |
| stallCnt0 | output | CNT_W | Requester 0 stall-cycle count |
| req1Valid | input | 1 | Requester 1 presents a load |
| req1Addr | input | ADDR_W | Requester 1 byte address |
| req1Stall | output | 1 | Requester 1 load held by a bank collision |
| rsp1Valid | output | 1 | Requester 1 load word valid |
| rsp1Data | output | 64 | Requester 1 load word |
| cntClr1 | input | 1 | Clear requester 1 stall counter |
| stallCnt1 | output | CNT_W | Requester 1 stall-cycle count |
| fillEn | input | 1 | Write one word into the banks |
| fillAddr | input | ADDR_W | Fill byte address |
| fillData | input | 64 | Fill word |

## Verification
The bench aims at collisions between different lines in one bank and at two requesters reading the identical address. A design that decoded the bank from the wrong bits, or compared whole addresses, would let both loads through there or stall loads that never met. Long same-bank bursts check the alternation of priority. A fixed priority would stall one requester twice in a row and starve it. A clear raised in the very cycle of a stall catches a counter that gives increment precedence. A fill and a load to the same word in one cycle catch a bank that forwards the new word instead of returning the old one. Address bits [2:0] are varied freely, which exposes any design that decodes the bank or the line from them.

// File: rtl/bank_store_pkg.sv
package bank_store_pkg;
  localparam int REQ_COUNT = 2;

  // Control to datapath strobes: which requester is served this cycle.
  typedef struct packed {
    logic [REQ_COUNT-1:0] grant;
  } bank_strobe_t;
endpackage

// File: rtl/bank_arbiter.sv
module bank_arbiter
  import bank_store_pkg::*;
#(
  parameter int SEL_W = 3,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req0Valid,
  input  logic [SEL_W-1:0] req0Bank,
  input  logic             req1Valid,
  input  logic [SEL_W-1:0] req1Bank,
  input  logic             cntClr0,
  input  logic             cntClr1,
  output bank_strobe_t     strobe,
  output logic             req0Stall,
  output logic             req1Stall,
  output logic [CNT_W-1:0] stallCnt0,
  output logic [CNT_W-1:0] stallCnt1
);
  logic collide;
  logic prioOne;  // 1: requester 1 wins the next collision
  logic [REQ_COUNT-1:0] stallVec;
  logic [REQ_COUNT-1:0] clrVec;
  logic [CNT_W-1:0] cntArr [REQ_COUNT];

  assign collide = req0Valid && req1Valid && (req0Bank == req1Bank);

  always_comb begin
    strobe.grant[0] = req0Valid && (!collide || !prioOne);
    strobe.grant[1] = req1Valid && (!collide || prioOne);
  end

  assign stallVec = {req1Valid && !strobe.grant[1], req0Valid && !strobe.grant[0]};
  assign clrVec   = {cntClr1, cntClr0};
  assign req0Stall = stallVec[0];
  assign req1Stall = stallVec[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       prioOne <= 1'b0;
    else if (collide) prioOne <= !prioOne;
  end

  for (genvar r = 0; r < REQ_COUNT; r++) begin : gCnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cntArr[r] <= '0;
      else if (clrVec[r])   cntArr[r] <= '0;
      else if (stallVec[r]) cntArr[r] <= cntArr[r] + 1'b1;
    end
  end

  assign stallCnt0 = cntArr[0];
  assign stallCnt1 = cntArr[1];

  // R2: distinct banks never stall
  p_distinct_no_stall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req0Valid && req1Valid && req0Bank != req1Bank) |-> (!req0Stall && !req1Stall));
  // R3: a same-bank pair stalls exactly one requester
  p_one_loser_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req0Valid && req1Valid && req0Bank == req1Bank) |-> (req0Stall != req1Stall));
  // R5: no requester stalls on two consecutive cycles
  p_no_repeat_stall0_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req0Stall |=> !req0Stall);
  p_no_repeat_stall1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req1Stall |=> !req1Stall);
  // R7: counter follows stall and clear
  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cntClr0 |=> (stallCnt0 == '0));
  p_cnt_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req0Stall && !cntClr0) |=> (stallCnt0 == CNT_W'($past(stallCnt0) + 1'b1)));
endmodule

// File: rtl/bank_array.sv
module bank_array
  import bank_store_pkg::*;
#(
  parameter int NUM_BANKS  = 8,
  parameter int SEL_W      = 3,
  parameter int LINE_COUNT = 128,
  parameter int LINE_W     = 7,
  parameter int DATA_W     = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_strobe_t      strobe,
  input  logic [SEL_W-1:0]  req0Bank,
  input  logic [LINE_W-1:0] req0Line,
  input  logic [SEL_W-1:0]  req1Bank,
  input  logic [LINE_W-1:0] req1Line,
  input  logic              fillEn,
  input  logic [SEL_W-1:0]  fillBank,
  input  logic [LINE_W-1:0] fillLine,
  input  logic [DATA_W-1:0] fillData,
  output logic              rsp0Valid,
  output logic [DATA_W-1:0] rsp0Data,
  output logic              rsp1Valid,
  output logic [DATA_W-1:0] rsp1Data
);
  logic [DATA_W-1:0] bankOut [NUM_BANKS];
  logic [SEL_W-1:0]  rsp0Bank, rsp1Bank;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : gBank
    logic [DATA_W-1:0] mem [LINE_COUNT];
    logic [DATA_W-1:0] q;
    logic hit0, hit1;
    assign hit0 = strobe.grant[0] && (req0Bank == SEL_W'(b));
    assign hit1 = strobe.grant[1] && (req1Bank == SEL_W'(b));

    // One read port per bank; read returns the pre-write word.
    always_ff @(posedge clk) begin
      if (fillEn && (fillBank == SEL_W'(b))) mem[fillLine] <= fillData;
      if (hit0 || hit1) q <= mem[hit0 ? req0Line : req1Line];
    end
    assign bankOut[b] = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp0Valid <= 1'b0;
      rsp1Valid <= 1'b0;
      rsp0Bank  <= '0;
      rsp1Bank  <= '0;
    end else begin
      rsp0Valid <= strobe.grant[0];
      rsp1Valid <= strobe.grant[1];
      if (strobe.grant[0]) rsp0Bank <= req0Bank;
      if (strobe.grant[1]) rsp1Bank <= req1Bank;
    end
  end

  assign rsp0Data = bankOut[rsp0Bank];
  assign rsp1Data = bankOut[rsp1Bank];

  // R3: the datapath is never asked for two reads of one bank
  p_single_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.grant[0] && strobe.grant[1]) |-> (req0Bank != req1Bank));
endmodule

// File: rtl/bank_conflict_store.sv
module bank_conflict_store
  import bank_store_pkg::*;
#(
  parameter int LINE_BYTES = 64,
  parameter int BANK_BYTES = 8,
  parameter int LINE_COUNT = 128,
  parameter int CNT_W      = 16,
  localparam int NUM_BANKS = LINE_BYTES / BANK_BYTES,
  localparam int SEL_W     = $clog2(NUM_BANKS),
  localparam int OFS_W     = $clog2(BANK_BYTES),
  localparam int LINE_LSB  = $clog2(LINE_BYTES),
  localparam int LINE_W    = $clog2(LINE_COUNT),
  localparam int ADDR_W    = LINE_LSB + LINE_W,
  localparam int DATA_W    = BANK_BYTES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req0Valid,
  input  logic [ADDR_W-1:0] req0Addr,
  output logic              req0Stall,
  output logic              rsp0Valid,
  output logic [DATA_W-1:0] rsp0Data,
  input  logic              cntClr0,
  output logic [CNT_W-1:0]  stallCnt0,
  input  logic              req1Valid,
  input  logic [ADDR_W-1:0] req1Addr,
  output logic              req1Stall,
  output logic              rsp1Valid,
  output logic [DATA_W-1:0] rsp1Data,
  input  logic              cntClr1,
  output logic [CNT_W-1:0]  stallCnt1,
  input  logic              fillEn,
  input  logic [ADDR_W-1:0] fillAddr,
  input  logic [DATA_W-1:0] fillData
);
  bank_strobe_t strobe;
  logic [SEL_W-1:0]  bank0, bank1, fillBank;
  logic [LINE_W-1:0] line0, line1, fillLine;
  logic unusedOfs;

  assign bank0    = req0Addr[OFS_W +: SEL_W];
  assign bank1    = req1Addr[OFS_W +: SEL_W];
  assign fillBank = fillAddr[OFS_W +: SEL_W];
  assign line0    = req0Addr[LINE_LSB +: LINE_W];
  assign line1    = req1Addr[LINE_LSB +: LINE_W];
  assign fillLine = fillAddr[LINE_LSB +: LINE_W];
  assign unusedOfs = ^{req0Addr[OFS_W-1:0], req1Addr[OFS_W-1:0], fillAddr[OFS_W-1:0]};

  bank_arbiter #(.SEL_W(SEL_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rst_n(rst_n),
    .req0Valid(req0Valid), .req0Bank(bank0),
    .req1Valid(req1Valid), .req1Bank(bank1),
    .cntClr0(cntClr0), .cntClr1(cntClr1),
    .strobe(strobe),
    .req0Stall(req0Stall), .req1Stall(req1Stall),
    .stallCnt0(stallCnt0), .stallCnt1(stallCnt1)
  );

  bank_array #(.NUM_BANKS(NUM_BANKS), .SEL_W(SEL_W), .LINE_COUNT(LINE_COUNT),
               .LINE_W(LINE_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .req0Bank(bank0), .req0Line(line0),
    .req1Bank(bank1), .req1Line(line1),
    .fillEn(fillEn), .fillBank(fillBank), .fillLine(fillLine), .fillData(fillData),
    .rsp0Valid(rsp0Valid), .rsp0Data(rsp0Data),
    .rsp1Valid(rsp1Valid), .rsp1Data(rsp1Data)
  );
endmodule

// File: tb/bank_conflict_store_test.sv
module bank_conflict_store_test;
  localparam int AW = 13;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic v0 = 0, v1 = 0, c0 = 0, c1 = 0, fEn = 0;
  logic [AW-1:0] a0 = '0, a1 = '0, fA = '0;
  logic [63:0] fD = '0;
  logic s0, s1, rv0, rv1;
  logic [63:0] rd0, rd1;
  logic [15:0] cnt0, cnt1;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Behavioural model state
  logic [63:0] mdl [int];
  bit mPrio = 0;
  int mCnt0 = 0, mCnt1 = 0;

  always #5 clk = ~clk;

  bank_conflict_store uut (
    .clk(clk), .rst_n(rst_n),
    .req0Valid(v0), .req0Addr(a0), .req0Stall(s0), .rsp0Valid(rv0), .rsp0Data(rd0),
    .cntClr0(c0), .stallCnt0(cnt0),
    .req1Valid(v1), .req1Addr(a1), .req1Stall(s1), .rsp1Valid(rv1), .rsp1Data(rd1),
    .cntClr1(c1), .stallCnt1(cnt1),
    .fillEn(fEn), .fillAddr(fA), .fillData(fD)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [63:0] pat(input int line, input int bank);
    return {16'hC0DE, 16'(line), 16'(bank), 16'(line ^ (bank * 7))};
  endfunction

  // One clock with model comparison; returns grants for the requester drivers.
  task automatic doCycle(input bit iv0, input logic [AW-1:0] ia0, input bit iv1,
                         input logic [AW-1:0] ia1, input bit ic0, input bit ic1,
                         input bit iF, input logic [AW-1:0] iFA, input logic [63:0] iFD,
                         input string tag, output bit g0, output bit g1);
    bit conf;
    logic [63:0] e0, e1;
    @(negedge clk);
    v0 = iv0; a0 = ia0; v1 = iv1; a1 = ia1; c0 = ic0; c1 = ic1;
    fEn = iF; fA = iFA; fD = iFD;
    #1;
    conf = iv0 && iv1 && (ia0[5:3] == ia1[5:3]);
    g0 = iv0 && (!conf || !mPrio);
    g1 = iv1 && (!conf || mPrio);
    chk({tag, " R3 stall0"}, 64'(s0), 64'(iv0 && !g0));
    chk({tag, " R3 stall1"}, 64'(s1), 64'(iv1 && !g1));
    e0 = g0 ? mdl[int'(ia0 >> 3)] : '0;
    e1 = g1 ? mdl[int'(ia1 >> 3)] : '0;
    @(posedge clk);
    #1;
    if (conf) mPrio = !mPrio;
    if (ic0) mCnt0 = 0; else if (iv0 && !g0) mCnt0++;
    if (ic1) mCnt1 = 0; else if (iv1 && !g1) mCnt1++;
    if (iF) mdl[int'(iFA >> 3)] = iFD;
    chk({tag, " R2 rspValid0"}, 64'(rv0), 64'(g0));
    chk({tag, " R2 rspValid1"}, 64'(rv1), 64'(g1));
    if (g0) chk({tag, " R6 data0"}, rd0, e0);
    if (g1) chk({tag, " R6 data1"}, rd1, e1);
    chk({tag, " R7 cnt0"}, 64'(cnt0), 64'(mCnt0 & 16'hFFFF));
    chk({tag, " R7 cnt1"}, 64'(cnt1), 64'(mCnt1 & 16'hFFFF));
  endtask

  // Two load streams; a stalled load is held until served.
  task automatic burst(input logic [AW-1:0] q0[$], input logic [AW-1:0] q1[$], input string tag);
    bit g0, g1;
    while (q0.size() > 0 || q1.size() > 0) begin
      doCycle(q0.size() > 0, q0.size() > 0 ? q0[0] : '0,
              q1.size() > 0, q1.size() > 0 ? q1[0] : '0,
              0, 0, 0, '0, '0, tag, g0, g1);
      if (g0) void'(q0.pop_front());
      if (g1) void'(q1.pop_front());
    end
  endtask

  initial begin
    bit g0, g1;
    logic [AW-1:0] qa[$];
    logic [AW-1:0] qb[$];
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1 rspValid0", 64'(rv0), 0);
    chk("R1 rspValid1", 64'(rv1), 0);
    chk("R1 stall0", 64'(s0), 0);
    chk("R1 stall1", 64'(s1), 0);
    chk("R1 cnt0", 64'(cnt0), 0);
    chk("R1 cnt1", 64'(cnt1), 0);
    rst_n = 1'b1;

    // Fill 16 lines, all banks
    for (int l = 0; l < 16; l++)
      for (int b = 0; b < 8; b++)
        doCycle(0, '0, 0, '0, 0, 0, 1, AW'(l * 64 + b * 8), pat(l, b), "fill", g0, g1);

    // R1/R3: first collision, different lines same bank, requester 0 wins
    qa = {AW'(2 * 64 + 3 * 8)}; qb = {AW'(9 * 64 + 3 * 8)};
    burst(qa, qb, "R1 first collision");
    // R2: different banks served together
    qa = {AW'(1 * 64 + 0), AW'(4 * 64 + 2 * 8)}; qb = {AW'(1 * 64 + 8), AW'(4 * 64 + 7 * 8)};
    burst(qa, qb, "R2 distinct banks");
    // R4/R5: same-bank bursts alternate
    qa = {}; qb = {};
    for (int i = 0; i < 6; i++) begin
      qa.push_back(AW'(i * 64 + 5 * 8));
      qb.push_back(AW'((15 - i) * 64 + 5 * 8));
    end
    burst(qa, qb, "R4 alternating");
    // R3: identical address on both
    qa = {AW'(7 * 64 + 6 * 8), AW'(7 * 64 + 6 * 8)}; qb = {AW'(7 * 64 + 6 * 8), AW'(7 * 64 + 6 * 8)};
    burst(qa, qb, "R3 same address");
    // R6: low bits [2:0] ignored
    qa = {AW'(3 * 64 + 1 * 8 + 5), AW'(3 * 64 + 2 * 8 + 7)}; qb = {AW'(12 * 64 + 4 * 8 + 3)};
    burst(qa, qb, "R6 low bits");
    // R7: clear wins over a stall in the same cycle
    doCycle(1, AW'(64 + 16), 1, AW'(128 + 16), 0, 1, 0, '0, '0, "R7 clear on stall", g0, g1);
    doCycle(!g0, AW'(64 + 16), !g1, AW'(128 + 16), 1, 0, 0, '0, '0, "R7 clear 0", g0, g1);
    // R8: fill and load to the same word in one cycle
    doCycle(1, AW'(5 * 64 + 4 * 8), 0, '0, 0, 0, 1, AW'(5 * 64 + 4 * 8), 64'h0123_4567_89AB_CDEF,
            "R8 same-cycle fill", g0, g1);
    doCycle(1, AW'(5 * 64 + 4 * 8), 0, '0, 0, 0, 0, '0, '0, "R8 after fill", g0, g1);
    // Mixed random traffic
    qa = {}; qb = {};
    for (int i = 0; i < 300; i++) begin
      qa.push_back(AW'($urandom_range(0, 1023)));
      qb.push_back(AW'($urandom_range(0, 1023)));
    end
    burst(qa, qb, "R5 random mix");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule